// File: doc/BRIEF.md
# Remote-Control Pulse Capture Receiver

This block measures the envelope of a remote-control signal that has already been demodulated, whether infrared or radio. It records each symbol as a pair of counts. The mark count is how long the active level lasted. The symbol count is the time from the start of that mark to the start of the next one. Software derives the space by subtracting the mark count from the symbol count. Both counts are in sample ticks. The tick is the system clock divided by a programmable integer, which is normally chosen to give a 10 MHz sample rate.

Completed pairs enter an eight-entry FIFO, which software drains through a small register interface. If the input stays idle for longer than a programmable limit after a mark, the block closes that symbol with the all-ones code, which tells software the train has ended. Four sticky interrupt sources, each with its own enable, drive one level interrupt line. An inversion control lets the block accept active-low input pins.

Top module: `irCaptureRx`

## Requirements
- R1: Each entry's mark count equals the number of sample ticks during which the active level was present.
- R2: Each entry's symbol count equals the number of ticks from the start of its mark to the start of the next mark. The entry is pushed when that next mark begins.
- R3: One tick occurs every D system clocks, where D is the divisor register at address 2. A divisor of 0 behaves as 1.
- R4: When bit 0 of the polarity register at address 1 is 1, the input is inverted before measurement, so a low input counts as mark.
- R5: When the symbol count would reach the limit register at address 3 while no new mark has started, the symbol closes. Its entry holds the mark count and the symbol value 16'hFFFF, and interrupt status bit 1 is set.
- R6: The FIFO holds 8 entries, read out oldest first. Reading address 8 returns the head mark count and does not pop. Reading address 9 returns the head symbol count and pops the entry. Bits 15:8 of the status register at address 7 hold the fill level.
- R7: When a pair is pushed into a full FIFO, the pair is dropped and the stored entries are kept. Interrupt status bit 2 is set and stays set until it is cleared, and status register bit 2 mirrors it.
- R8: The interrupt status register at address 5 has these sticky bits: bit 0 is set on an accepted push, bit 1 on a timeout close, bit 2 on overrun, and bit 3 when a push fills the FIFO. Enables at the same bit positions are in address 4. The interrupt output is high while any status bit is set together with its enable.
- R9: Writing to address 6 clears each interrupt status bit whose data bit is 1. All other status bits are left unchanged.
- R10: While bit 0 of the receive-enable register at address 0 is 0, nothing is captured and nothing is pushed.
- R11: Ordinary mark and symbol counts saturate at 16'hFFFE.
- R12: After reset the block is in this state: divisor 1, limit 16'hFFFF, receive disabled, inversion off, FIFO empty, all status bits 0, interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| irIn | input | 1 | Demodulated envelope input, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, which pops the FIFO at address 9 |
| regAddr | input | 4 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |

## Verification
A completed pair enters the FIFO three clocks after the input edge that starts the next mark: two clocks pass through the synchronizer flops and one clock lands in the capture registers. The bench always waits eight clocks after that edge before it reads. A register write takes effect on the clock edge that captures it. Read data follows the address combinationally, so the bench applies each read at a falling edge, samples 1 ns later, and lets the next rising edge perform any pop. The input is changed only at falling edges and held for whole multiples of the divisor, so every expected count is an exact number of ticks.

// File: rtl/irCapturePkg.sv
package irCapturePkg;

  typedef struct packed {
    logic startMark;
    logic countMark;
    logic countSym;
    logic closeNormal;
    logic closeTimeout;
  } ctlStb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} capState_t;

  localparam logic [3:0] ADDR_RXEN    = 4'd0;
  localparam logic [3:0] ADDR_POL     = 4'd1;
  localparam logic [3:0] ADDR_DIV     = 4'd2;
  localparam logic [3:0] ADDR_MAXSYM  = 4'd3;
  localparam logic [3:0] ADDR_INTEN   = 4'd4;
  localparam logic [3:0] ADDR_INTSTAT = 4'd5;
  localparam logic [3:0] ADDR_INTCLR  = 4'd6;
  localparam logic [3:0] ADDR_STATUS  = 4'd7;
  localparam logic [3:0] ADDR_MARK    = 4'd8;
  localparam logic [3:0] ADDR_SYM     = 4'd9;

  localparam int INT_DATA    = 0;
  localparam int INT_TIMEOUT = 1;
  localparam int INT_OVERRUN = 2;
  localparam int INT_FULL    = 3;

endpackage

// File: rtl/irRxCtrl.sv
module irRxCtrl
  import irCapturePkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          irIn,
  input  logic          rxEn,
  input  logic          polInv,
  input  logic [CW-1:0] divisor,
  input  logic          symAtLimit,
  output ctlStb_t       stb
);

  logic [1:0]    syncQ;
  logic [CW-1:0] divCnt;
  logic [CW-1:0] divEff;
  logic          tick;
  logic          lvl;
  logic          prevLvl;
  capState_t     state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], irIn};
  end

  assign divEff = (divisor == '0) ? CW'(1) : divisor;
  assign tick   = (divCnt >= divEff - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + CW'(1);
  end

  assign lvl = syncQ[1] ^ polInv;

  always_ff @(posedge clk) begin
    if (!rstN)     prevLvl <= 1'b0;
    else if (tick) prevLvl <= lvl;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    if (!rxEn) begin
      nextState = ST_IDLE;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (lvl && !prevLvl) begin
            stb.startMark = 1'b1;
            nextState     = ST_MARK;
          end
        end
        ST_MARK: begin
          stb.countSym = 1'b1;
          if (lvl) stb.countMark = 1'b1;
          else     nextState     = ST_SPACE;
        end
        ST_SPACE: begin
          if (lvl) begin
            stb.closeNormal = 1'b1;
            stb.startMark   = 1'b1;
            nextState       = ST_MARK;
          end else if (symAtLimit) begin
            stb.closeTimeout = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            stb.countSym = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/irRxDatapath.sv
module irRxDatapath
  import irCapturePkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          CW         = 16,
  parameter logic [15:0] RST_DIV    = 16'd1,
  parameter logic [15:0] RST_MAXSYM = 16'hFFFF,
  localparam int         PW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         NW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStb_t       stb,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [3:0]    regAddr,
  input  logic [CW-1:0] regWrData,
  output logic [CW-1:0] regRdData,
  output logic          rxEn,
  output logic          polInv,
  output logic [CW-1:0] divisor,
  output logic          symAtLimit,
  output logic [NW-1:0] fifoCount,
  output logic [3:0]    intStat,
  output logic          irq
);

  localparam logic [CW-1:0] SAT_MAX  = {CW{1'b1}} - CW'(1);
  localparam logic [CW-1:0] TO_CODE  = {CW{1'b1}};
  localparam logic [NW-1:0] FULL_CNT = NW'(DEPTH);

  function automatic logic [CW-1:0] satInc(input logic [CW-1:0] v);
    return (v >= SAT_MAX) ? SAT_MAX : v + CW'(1);
  endfunction

  function automatic logic [PW-1:0] ptrInc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [CW-1:0] markCnt, symCnt;
  logic [CW-1:0] maxSym;
  logic [3:0]    intEn;
  logic [CW-1:0] markMem [DEPTH];
  logic [CW-1:0] symMem  [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          pushReq, fifoFull, accept, popReq;
  logic [CW-1:0] pushSym;
  logic [3:0]    setBits, clrBits;

  // measurement counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      markCnt <= '0;
      symCnt  <= '0;
    end else if (stb.startMark) begin
      markCnt <= CW'(1);
      symCnt  <= CW'(1);
    end else begin
      if (stb.countMark) markCnt <= satInc(markCnt);
      if (stb.countSym)  symCnt  <= satInc(symCnt);
    end
  end

  assign symAtLimit = (satInc(symCnt) >= maxSym);

  // sample FIFO
  assign pushReq  = stb.closeNormal | stb.closeTimeout;
  assign pushSym  = stb.closeTimeout ? TO_CODE : symCnt;
  assign fifoFull = (fifoCount == FULL_CNT);
  assign accept   = pushReq && !fifoFull;
  assign popReq   = regRdEn && (regAddr == ADDR_SYM) && (fifoCount != '0);

  always_ff @(posedge clk) begin
    if (accept) begin
      markMem[wrPtr] <= markCnt;
      symMem[wrPtr]  <= pushSym;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (accept) wrPtr <= ptrInc(wrPtr);
      if (popReq) rdPtr <= ptrInc(rdPtr);
      fifoCount <= fifoCount + NW'(accept) - NW'(popReq);
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn    <= 1'b0;
      polInv  <= 1'b0;
      divisor <= CW'(RST_DIV);
      maxSym  <= CW'(RST_MAXSYM);
      intEn   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_RXEN:   rxEn    <= regWrData[0];
        ADDR_POL:    polInv  <= regWrData[0];
        ADDR_DIV:    divisor <= regWrData;
        ADDR_MAXSYM: maxSym  <= regWrData;
        ADDR_INTEN:  intEn   <= regWrData[3:0];
        default: ;
      endcase
    end
  end

  // sticky interrupt status
  always_comb begin
    setBits              = '0;
    setBits[INT_DATA]    = accept;
    setBits[INT_TIMEOUT] = stb.closeTimeout;
    setBits[INT_OVERRUN] = pushReq && fifoFull;
    setBits[INT_FULL]    = accept && !popReq && (fifoCount == FULL_CNT - NW'(1));
    clrBits = (regWrEn && regAddr == ADDR_INTCLR) ? regWrData[3:0] : 4'h0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) intStat <= '0;
    else       intStat <= (intStat & ~clrBits) | setBits;
  end

  assign irq = |(intStat & intEn);

  // read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_RXEN:    regRdData[0] = rxEn;
      ADDR_POL:     regRdData[0] = polInv;
      ADDR_DIV:     regRdData = divisor;
      ADDR_MAXSYM:  regRdData = maxSym;
      ADDR_INTEN:   regRdData[3:0] = intEn;
      ADDR_INTSTAT: regRdData[3:0] = intStat;
      ADDR_STATUS: begin
        regRdData[NW+7:8] = fifoCount;
        regRdData[2]      = intStat[INT_OVERRUN];
      end
      ADDR_MARK:    regRdData = (fifoCount != '0) ? markMem[rdPtr] : '0;
      ADDR_SYM:     regRdData = (fifoCount != '0) ? symMem[rdPtr] : '0;
      default: ;
    endcase
  end

endmodule

// File: rtl/irCaptureRx.sv
module irCaptureRx
  import irCapturePkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          CW         = 16,
  parameter logic [15:0] RST_DIV    = 16'd1,
  parameter logic [15:0] RST_MAXSYM = 16'hFFFF,
  localparam int         NW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          irIn,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [3:0]    regAddr,
  input  logic [CW-1:0] regWrData,
  output logic [CW-1:0] regRdData,
  output logic          irq
);

  ctlStb_t       stb;
  logic          rxEn, polInv, symAtLimit;
  logic [CW-1:0] divisor;
  logic [NW-1:0] fifoCount;
  logic [3:0]    intStat;

  irRxCtrl #(.CW(CW)) ctrl (
    .clk(clk), .rstN(rstN), .irIn(irIn), .rxEn(rxEn), .polInv(polInv),
    .divisor(divisor), .symAtLimit(symAtLimit), .stb(stb)
  );

  irRxDatapath #(
    .DEPTH(DEPTH), .CW(CW), .RST_DIV(RST_DIV), .RST_MAXSYM(RST_MAXSYM)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxEn(rxEn), .polInv(polInv), .divisor(divisor), .symAtLimit(symAtLimit),
    .fifoCount(fifoCount), .intStat(intStat), .irq(irq)
  );

endmodule

// File: rtl/irCaptureRxChk.sv
module irCaptureRxChk
  import irCapturePkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input ctlStb_t       stb,
  input logic          rxEn,
  input logic [NW-1:0] fifoCount,
  input logic [3:0]    intStat,
  input logic          regWrEn,
  input logic          regRdEn,
  input logic [3:0]    regAddr,
  input logic [CW-1:0] regWrData
);

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= NW'(DEPTH));

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.closeNormal || stb.closeTimeout) && fifoCount == NW'(DEPTH)
      && !(regRdEn && regAddr == ADDR_SYM)) |=> fifoCount == NW'(DEPTH));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStat[INT_OVERRUN] && !(regWrEn && regAddr == ADDR_INTCLR && regWrData[INT_OVERRUN]))
      |=> intStat[INT_OVERRUN]);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> !(stb.startMark || stb.closeNormal || stb.closeTimeout));

  // R5
  close_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.closeNormal, stb.closeTimeout}));

endmodule

bind irCaptureRx irCaptureRxChk #(.DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .stb(stb), .rxEn(rxEn), .fifoCount(fifoCount),
  .intStat(intStat), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWrData(regWrData)
);

// File: tb/tb_irCaptureRx.sv
module tb_irCaptureRx;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        irq;
  logic        activeLvl = 1'b1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  irCaptureRx dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic idleLvl);
    @(negedge clk);
    rstN = 1'b0;
    irIn = idleLvl;
    activeLvl = ~idleLvl;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(input int markC, input int spaceC);
    @(negedge clk);
    irIn = activeLvl;
    repeat (markC) @(negedge clk);
    irIn = ~activeLvl;
    repeat (spaceC - 1) @(negedge clk);
  endtask

  task automatic finalMark();
    @(negedge clk);
    irIn = activeLvl;
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    doReset(1'b0);
    rdCheck("R12 divisor", 4'd2, 16'd1);
    rdCheck("R12 limit", 4'd3, 16'hFFFF);
    rdCheck("R12 rxen", 4'd0, 16'd0);
    rdCheck("R12 status", 4'd7, 16'd0);
    rdCheck("R12 intstat", 4'd5, 16'd0);
    check("R12 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic testBasic();
    doReset(1'b0);
    wr(4'd0, 16'd1);
    pulse(20, 30);
    pulse(12, 8);
    finalMark();
    rdCheck("R6 fill level", 4'd7, 16'h0200);
    rdCheck("R1 first mark", 4'd8, 16'd20);
    rdCheck("R6 mark read no pop", 4'd8, 16'd20);
    rdCheck("R6 fill after mark reads", 4'd7, 16'h0200);
    rdCheck("R2 first symbol", 4'd9, 16'd50);
    rdCheck("R1 second mark", 4'd8, 16'd12);
    rdCheck("R2 second symbol", 4'd9, 16'd20);
    rdCheck("R6 empty after pops", 4'd7, 16'h0000);
  endtask

  task automatic testDivisor();
    doReset(1'b0);
    wr(4'd2, 16'd4);
    wr(4'd0, 16'd1);
    pulse(40, 60);
    finalMark();
    rdCheck("R3 mark div4", 4'd8, 16'd10);
    rdCheck("R3 symbol div4", 4'd9, 16'd25);
    doReset(1'b0);
    wr(4'd2, 16'd0);
    wr(4'd0, 16'd1);
    pulse(20, 30);
    finalMark();
    rdCheck("R3 mark div0", 4'd8, 16'd20);
    rdCheck("R3 symbol div0", 4'd9, 16'd50);
  endtask

  task automatic testPolarity();
    doReset(1'b1);
    wr(4'd1, 16'd1);
    wr(4'd0, 16'd1);
    repeat (4) @(negedge clk);
    rdCheck("R4 idle high not captured", 4'd7, 16'h0000);
    pulse(15, 25);
    finalMark();
    rdCheck("R4 inverted mark", 4'd8, 16'd15);
    rdCheck("R4 inverted symbol", 4'd9, 16'd40);
  endtask

  task automatic testTimeout();
    doReset(1'b0);
    wr(4'd3, 16'd100);
    wr(4'd4, 16'h0002);
    wr(4'd0, 16'd1);
    check("R8 irq idle", {15'd0, irq}, 16'd0);
    pulse(10, 200);
    rdCheck("R5 intstat", 4'd5, 16'h0003);
    check("R8 irq timeout", {15'd0, irq}, 16'd1);
    rdCheck("R5 mark", 4'd8, 16'd10);
    rdCheck("R5 timeout code", 4'd9, 16'hFFFF);
    wr(4'd6, 16'h0002);
    rdCheck("R9 clear bit1 only", 4'd5, 16'h0001);
    check("R8 irq after clear", {15'd0, irq}, 16'd0);
    wr(4'd4, 16'h0001);
    check("R8 irq data enable", {15'd0, irq}, 16'd1);
    wr(4'd6, 16'h000F);
    rdCheck("R9 clear all", 4'd5, 16'h0000);
    check("R8 irq low", {15'd0, irq}, 16'd0);
  endtask

  task automatic testOverrun();
    doReset(1'b0);
    wr(4'd0, 16'd1);
    for (int i = 0; i < 10; i++) pulse(i + 2, 6);
    repeat (8) @(negedge clk);
    rdCheck("R7 status full overrun", 4'd7, 16'h0804);
    rdCheck("R7 intstat", 4'd5, 16'h000D);
    for (int k = 0; k < 8; k++) begin
      rdCheck("R7 kept mark", 4'd8, 16'(k + 2));
      rdCheck("R7 kept symbol", 4'd9, 16'(k + 8));
      if (k == 0) rdCheck("R7 overrun sticky", 4'd7, 16'h0704);
    end
    rdCheck("R6 drained", 4'd7, 16'h0004);
    wr(4'd6, 16'h0004);
    rdCheck("R9 clear overrun", 4'd5, 16'h0009);
    rdCheck("R7 status cleared", 4'd7, 16'h0000);
  endtask

  task automatic testDisabled();
    doReset(1'b0);
    for (int i = 0; i < 3; i++) pulse(10, 10);
    finalMark();
    rdCheck("R10 nothing captured", 4'd7, 16'h0000);
    rdCheck("R10 no status", 4'd5, 16'h0000);
  endtask

  task automatic testSaturate();
    doReset(1'b0);
    wr(4'd0, 16'd1);
    pulse(65600, 10);
    finalMark();
    rdCheck("R11 mark saturated", 4'd8, 16'hFFFE);
    rdCheck("R11 symbol saturated", 4'd9, 16'hFFFE);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testBasic();
    testDivisor();
    testPolarity();
    testTimeout();
    testOverrun();
    testDisabled();
    testSaturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule